// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides how a dual-reference timing DPLL behaves from moment to moment. It watches a reference-select pin, a validity flag for the active reference, a free-run request and a request for the phase-step absorber (the time-interval-error buffer that hides phase hits when references change). From these it keeps the loop in one of four modes: normal tracking, a brief holdover while references are swapped, a long holdover while the reference is unusable, and free run from the master clock. It also chooses which of the two references feeds the loop, and it drives the status flags and the absorber enable.

The block also supplies the frequency word that the oscillator should use. While tracking, the word comes straight from the loop. While holding over, it is a sample the controller took from the loop one to two sample periods earlier, where a period is nominally 30 ms. That keeps any disturbance that came just before the reference failed out of the held value. In free run, the word is a fixed nominal value.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: In Normal (mode_o = 0), a change of ref_sel_i between consecutive clock edges moves the controller to Short Holdover (mode_o = 1) at that edge, provided ref_valid_i is high and freerun_req_i is low.
- R2: Short Holdover lasts until SETTLE_CYCLES consecutive edges pass with no change on ref_sel_i. Any change restarts the count. On expiry, ref_active_o inverts and the mode returns to Normal.
- R3: tie_en_o is low throughout Short Holdover. On the exit edge to Normal it takes the value of tie_en_req_i. No other transition alters it.
- R4: Low ref_valid_i in Normal or Short Holdover enters Holdover (mode_o = 2) at the next edge. High ref_valid_i in Holdover returns the controller to Normal at the next edge.
- R5: holdover_o is high exactly when mode_o = 2, and freerun_o is high exactly when mode_o = 3. The two are never high together.
- R6: Every SAMPLE_TICKS cycles, and only in Normal, loop_freq_i is stored as a sample. In Normal, freq_word_o equals loop_freq_i. On entry to Short Holdover or Holdover from Normal, the second-most-recent sample (zero if fewer than two exist) is latched and driven on freq_word_o, and it stays constant for the rest of the holdover.
- R7: A high freerun_req_i puts the controller in Free Run (mode_o = 3) at the next edge from any mode, overriding every other transition. In Free Run, freq_word_o equals NOMINAL_WORD. When the request drops, the controller returns to Normal.
- R8: Reset gives mode Normal, ref_active_o = 0, tie_en_o = 0, both status flags low and no stored samples.
- R9: Changes on ref_sel_i during Holdover or Free Run are ignored. They cause no Short Holdover and no reference swap, either at once or after the return to Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel_i | input | 1 | Reference-select pin; any change is a swap event |
| ref_valid_i | input | 1 | High while the active reference is usable |
| freerun_req_i | input | 1 | Forces Free Run while high |
| tie_en_req_i | input | 1 | Requested phase-step absorber enable |
| loop_freq_i | input | FW | Frequency word from the loop filter |
| mode_o | output | 2 | 0 Normal, 1 Short Holdover, 2 Holdover, 3 Free Run |
| ref_active_o | output | 1 | Index of the reference feeding the loop |
| tie_en_o | output | 1 | Phase-step absorber enable |
| holdover_o | output | 1 | Holdover status flag |
| freerun_o | output | 1 | Free Run status flag |
| freq_word_o | output | FW | Frequency word for the oscillator |

## Verification
The hardest case to reach is a Short Holdover whose quiet window restarts. This needs a second select change that falls strictly inside the window, followed by a check that the swap happens a full window after the last change and not after the first. The stimulus toggles the select pin twice, a few cycles apart, while the loop word keeps moving. A reference model then tracks the exact exit edge and the held word on every cycle. The held word is also driven through a case where only one sample exists and through entries that coincide with a sampling edge.

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl #(
  parameter int FW = 16,
  parameter int SAMPLE_TICKS = 1500000,
  parameter int SETTLE_CYCLES = 50000,
  parameter int RING_DEPTH = 4,
  parameter logic [FW-1:0] NOMINAL_WORD = {1'b1, {(FW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_sel_i,
  input  logic          ref_valid_i,
  input  logic          freerun_req_i,
  input  logic          tie_en_req_i,
  input  logic [FW-1:0] loop_freq_i,
  output logic [1:0]    mode_o,
  output logic          ref_active_o,
  output logic          tie_en_o,
  output logic          holdover_o,
  output logic          freerun_o,
  output logic [FW-1:0] freq_word_o
);
  localparam int TW = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
  localparam int QW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam int PW = $clog2(RING_DEPTH);

  typedef enum logic [1:0] {M_NORM = 2'd0, M_SHORT = 2'd1, M_HOLD = 2'd2, M_FREE = 2'd3} mode_t;

  mode_t         mode;
  logic          sel_q;
  logic [TW-1:0] tick_cnt;
  logic [QW-1:0] quiet_cnt;
  logic [PW-1:0] wptr;
  logic [FW-1:0] ring [RING_DEPTH];
  logic [FW-1:0] held;

  wire sel_event   = ref_sel_i ^ sel_q;
  wire tick_last   = (tick_cnt == TW'(SAMPLE_TICKS - 1));
  wire quiet_last  = (quiet_cnt == QW'(SETTLE_CYCLES - 1));
  wire [FW-1:0] aged_sample = ring[wptr - PW'(2)];

  always_ff @(posedge clk) sel_q <= ref_sel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      wptr     <= '0;
      for (int i = 0; i < RING_DEPTH; i++) ring[i] <= '0;
    end else begin
      tick_cnt <= tick_last ? '0 : tick_cnt + 1'b1;
      if (tick_last && mode == M_NORM) begin
        ring[wptr] <= loop_freq_i;
        wptr       <= wptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= M_NORM;
      ref_active_o <= 1'b0;
      tie_en_o     <= 1'b0;
      held         <= '0;
      quiet_cnt    <= '0;
    end else if (freerun_req_i) begin
      mode <= M_FREE;
    end else begin
      unique case (mode)
        M_FREE: mode <= M_NORM;
        M_NORM: begin
          if (!ref_valid_i) begin
            mode <= M_HOLD;
            held <= aged_sample;
          end else if (sel_event) begin
            mode      <= M_SHORT;
            held      <= aged_sample;
            tie_en_o  <= 1'b0;
            quiet_cnt <= '0;
          end
        end
        M_SHORT: begin
          if (!ref_valid_i) begin
            mode <= M_HOLD;
          end else if (sel_event) begin
            quiet_cnt <= '0;
          end else if (quiet_last) begin
            mode         <= M_NORM;
            ref_active_o <= ~ref_active_o;
            tie_en_o     <= tie_en_req_i;
          end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
          end
        end
        M_HOLD: if (ref_valid_i) mode <= M_NORM;
        default: mode <= M_NORM;
      endcase
    end
  end

  assign mode_o      = mode;
  assign holdover_o  = (mode == M_HOLD);
  assign freerun_o   = (mode == M_FREE);
  assign freq_word_o = (mode == M_NORM) ? loop_freq_i :
                       (mode == M_FREE) ? NOMINAL_WORD : held;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_sel_i,
  input logic          ref_valid_i,
  input logic          freerun_req_i,
  input logic          tie_en_req_i,
  input logic [1:0]    mode_o,
  input logic          ref_active_o,
  input logic          tie_en_o,
  input logic          holdover_o,
  input logic          freerun_o,
  input logic [FW-1:0] freq_word_o
);
  assert_enter_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && ref_valid_i && !freerun_req_i && ref_sel_i != $past(ref_sel_i))
      |=> (mode_o == 2'd1));

  assert_swap_on_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && $past(mode_o) == 2'd1) |-> (ref_active_o != $past(ref_active_o)));

  assert_tie_off_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> !tie_en_o);

  assert_tie_follow_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && $past(mode_o) == 2'd1) |-> (tie_en_o == $past(tie_en_req_i)));

  assert_enter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !ref_valid_i && !freerun_req_i) |=> (mode_o == 2'd2));

  assert_leave_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && ref_valid_i && !freerun_req_i) |=> (mode_o == 2'd0));

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(holdover_o && freerun_o) && (holdover_o == (mode_o == 2'd2)));

  assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) == 2'd2) |-> $stable(freq_word_o));

  assert_freerun_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freerun_req_i |=> (mode_o == 2'd3 && freerun_o));
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_sel_i(ref_sel_i), .ref_valid_i(ref_valid_i),
  .freerun_req_i(freerun_req_i), .tie_en_req_i(tie_en_req_i), .mode_o(mode_o),
  .ref_active_o(ref_active_o), .tie_en_o(tie_en_o), .holdover_o(holdover_o),
  .freerun_o(freerun_o), .freq_word_o(freq_word_o)
);

// File: tb/dpll_mode_ctrl_tb_top.sv
module dpll_mode_ctrl_tb_top;
  localparam int FW = 16;
  localparam int SAMP = 20;
  localparam int SETTLE = 8;
  localparam logic [FW-1:0] NOM = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_sel = 1'b0, ref_valid = 1'b1, fr_req = 1'b0, tie_req = 1'b0;
  logic [FW-1:0] loop_freq = 16'h1000;
  logic [1:0] mode;
  logic ref_act, tie_en, hold_f, free_f;
  logic [FW-1:0] fword;

  int checks = 0, errors = 0;
  string cur_req = "R8";

  always #10 clk = ~clk;

  dpll_mode_ctrl #(.FW(FW), .SAMPLE_TICKS(SAMP), .SETTLE_CYCLES(SETTLE),
                   .RING_DEPTH(4), .NOMINAL_WORD(NOM)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_sel_i(ref_sel), .ref_valid_i(ref_valid),
    .freerun_req_i(fr_req), .tie_en_req_i(tie_req), .loop_freq_i(loop_freq),
    .mode_o(mode), .ref_active_o(ref_act), .tie_en_o(tie_en),
    .holdover_o(hold_f), .freerun_o(free_f), .freq_word_o(fword)
  );

  // behavioural reference model
  int m_mode, m_quiet, m_tick;
  bit m_ref, m_tie, m_sel_q;
  logic [FW-1:0] m_held;
  logic [FW-1:0] samples[$];

  function automatic logic [FW-1:0] aged();
    return (samples.size() >= 2) ? samples[samples.size()-2] : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ref = 0; m_tie = 0; m_held = '0; m_quiet = 0; m_tick = 0;
      samples.delete();
    end else begin
      bit ev;
      int pm;
      ev = (ref_sel != m_sel_q);
      pm = m_mode;
      if (m_tick == SAMP-1 && pm == 0) samples.push_back(loop_freq);
      m_tick = (m_tick == SAMP-1) ? 0 : m_tick + 1;
      if (fr_req) m_mode = 3;
      else case (pm)
        3: m_mode = 0;
        0: if (!ref_valid) begin m_mode = 2; m_held = aged_pre; end
           else if (ev) begin m_mode = 1; m_held = aged_pre; m_tie = 0; m_quiet = 0; end
        1: if (!ref_valid) m_mode = 2;
           else if (ev) m_quiet = 0;
           else if (m_quiet == SETTLE-1) begin m_mode = 0; m_ref = ~m_ref; m_tie = tie_req; end
           else m_quiet++;
        2: if (ref_valid) m_mode = 0;
        default: m_mode = 0;
      endcase
    end
    if (clk) m_sel_q = ref_sel;
  end

  // aged sample as it stood before the current edge
  logic [FW-1:0] aged_pre;
  always @(negedge clk) aged_pre = aged();

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [FW-1:0] ef;
    ef = (m_mode == 0) ? loop_freq : (m_mode == 3) ? NOM : m_held;
    chk(cur_req, "mode", 32'(mode), 32'(m_mode));
    chk("R2", "ref_active", 32'(ref_act), 32'(m_ref));
    chk("R3", "tie_en", 32'(tie_en), 32'(m_tie));
    chk("R5", "holdover", 32'(hold_f), 32'(m_mode == 2));
    chk("R5", "freerun", 32'(free_f), 32'(m_mode == 3));
    chk("R6", "freq_word", 32'(fword), 32'(ef));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      loop_freq = loop_freq + 16'd37;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "reset mode", 32'(mode), 0);
    chk("R8", "reset ref", 32'(ref_act), 0);
    chk("R8", "reset tie", 32'(tie_en), 0);
    chk("R8", "reset flags", 32'({hold_f, free_f}), 0);
    rst_n = 1'b1;
    cur_req = "R6";
    step(15);
    // holdover with at most one sample stored: held word is zero
    cur_req = "R4"; ref_valid = 0; step(3);
    chk("R6", "held word with one sample", 32'(fword), 0);
    ref_valid = 1; step(60);

    cur_req = "R1"; tie_req = 1; ref_sel = ~ref_sel; step(2);
    chk("R1", "short holdover entered", 32'(mode), 1);
    cur_req = "R2"; step(SETTLE + 2);
    chk("R2", "swapped to ref 1", 32'(ref_act), 1);
    chk("R3", "tie follows request", 32'(tie_en), 1);

    // restart of the quiet window
    tie_req = 0; ref_sel = ~ref_sel; step(4);
    ref_sel = ~ref_sel; step(SETTLE - 1);
    chk("R2", "still short after restart", 32'(mode), 1);
    step(3);
    chk("R2", "back to ref 0", 32'(ref_act), 0);
    chk("R3", "tie cleared by request", 32'(tie_en), 0);
    step(45);

    // long holdover, selects ignored
    cur_req = "R4"; ref_valid = 0; step(3);
    chk("R4", "holdover entered", 32'(hold_f), 1);
    cur_req = "R9"; ref_sel = ~ref_sel; step(5); ref_sel = ~ref_sel; step(30);
    ref_valid = 1; step(SETTLE + 10);
    chk("R9", "no swap after holdover", 32'(ref_act), 0);
    chk("R9", "normal after holdover", 32'(mode), 0);

    // invalid during short holdover
    cur_req = "R4"; ref_sel = ~ref_sel; step(3); ref_valid = 0; step(4);
    chk("R4", "short to holdover", 32'(mode), 2);
    ref_valid = 1; step(25);

    // free run
    cur_req = "R7"; fr_req = 1; step(2);
    chk("R7", "nominal word", 32'(fword), 32'(NOM));
    ref_sel = ~ref_sel; ref_valid = 0; step(5); ref_valid = 1; step(5);
    fr_req = 0; step(SETTLE + 4);
    chk("R7", "normal after free run", 32'(mode), 0);
    chk("R9", "no swap after free run", 32'(ref_act), 0);
    cur_req = "R7"; ref_sel = ~ref_sel; step(3); fr_req = 1; step(3);
    chk("R7", "free run overrides short", 32'(mode), 3);
    fr_req = 0; step(30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule